// File: doc/BRIEF.md
# Prescaler Reset and Synchronized Timer Start Control

This block holds one control byte that governs two free-running clock prescalers. The first prescaler is shared by two timer/counters. The second one serves a separate timer, and here it runs from the same clock. Each prescaler turns its count into a set of single-cycle enable pulses (taps) at several divide ratios. Writing a prescaler-reset bit normally restarts that prescaler for exactly one cycle, and the bit clears itself.

A synchronization-mode bit changes how the reset bits behave: they become sticky. A prescaler whose reset bit is set stays at zero, its taps stay silent, and the timers it feeds cannot advance. Software can then load those timers with matching values. A single write that clears the mode bit also clears both reset bits, and every held timer restarts on the following clock.

Two small 8-bit demonstration counters make this visible. Counter A runs from the shared prescaler and counter B from the second one. Each counter picks a tap through a 3-bit select, and each can be loaded through a side port.

Top module: `prescalerSyncTop`

## Requirements
- R1: After reset the register reads 0x00, both counters read 0, and both prescalers start from a count of zero.
- R2: Register bits 6 down to 2 always read 0, and writing ones to them has no effect.
- R3: With bit 7 (mode) written 0, a 1 in bit 0 restarts the shared prescaler for one cycle: its taps are silent in the cycle after the write, and its count is zero in the cycle after that. Bit 0 then reads 0.
- R4: With bit 7 written 0, a 1 in bit 1 restarts the second prescaler in the same one-cycle way, and bit 1 then reads 0.
- R5: While bit 7 is 1, a reset bit written as 1 stays 1 and reads back as 1. Its prescaler stays at zero, all of its taps are silent, and its counter does not advance unless it is loaded.
- R6: A write with bit 7 equal to 0 clears both reset bits in that same write. In the next cycle each released prescaler is at zero and every one of its taps pulses.
- R7: A single write that sets bit 7 together with a reset bit keeps that reset bit set.
- R8: The shared prescaler taps, in order of tap bit 0 to 4, divide by 1, 8, 64, 256 and 1024. Each tap pulses when the prescaler count is a multiple of its ratio and the prescaler is not in reset.
- R9: The second prescaler taps, in order of tap bit 0 to 6, divide by 1, 8, 32, 64, 128, 256 and 1024, under the same pulse rule as R8.
- R10: A counter select of 0 stops the counter. A select of k (k from 1 up to the number of taps) picks tap bit k-1. A select above the number of taps also stops the counter. The counter adds 1, wrapping modulo 256, on the edge that ends a cycle in which its chosen tap pulses.
- R11: A load request writes the load value into its counter on the next edge, and a load takes priority over counting. Two counters loaded with the same value while held, then released together on the same tap ratio, stay equal afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read value |
| sharedTaps | output | 5 | Shared prescaler enable pulses |
| secondTaps | output | 7 | Second prescaler enable pulses |
| selA | input | 3 | Tap select for counter A (shared prescaler) |
| selB | input | 3 | Tap select for counter B (second prescaler) |
| loadA | input | 1 | Load strobe for counter A |
| loadAValue | input | 8 | Load value for counter A |
| loadB | input | 1 | Load strobe for counter B |
| loadBValue | input | 8 | Load value for counter B |
| countA | output | 8 | Counter A value |
| countB | output | 8 | Counter B value |

## Verification
The assertions assume that the inputs are stable around each rising edge. They also assume that a released prescaler was held at zero before it was released. For that reason the release check only fires when the read value showed the shared hold and the release write did not also request a one-cycle restart. The counter-freeze checks drop out in any cycle that carries a load request, so loads may be issued while counters are held. The stimulus changes every input on the falling edge. Its write sequences (hold, load, release, combined set, one-cycle restarts) stay within these assumptions.

// File: rtl/pscPkg.sv
package pscPkg;
  localparam int REG_W      = 8;
  localparam int PRESC_W    = 10;
  localparam int CNT_W      = 8;
  localparam int SEL_W      = 3;
  localparam int SHARED_NT  = 5;
  localparam int SECOND_NT  = 7;
  localparam int MODE_BIT   = 7;
  localparam int SECOND_BIT = 1;
  localparam int SHARED_BIT = 0;

  typedef int sharedShift_t [SHARED_NT];
  typedef int secondShift_t [SECOND_NT];
  localparam sharedShift_t SHARED_SHIFTS = '{0, 3, 6, 8, 10};
  localparam secondShift_t SECOND_SHIFTS = '{0, 3, 5, 6, 7, 8, 10};

  typedef struct packed {
    logic rstShared;
    logic rstSecond;
  } ctrlStrobes_t;
endpackage

// File: rtl/pscCtrl.sv
module pscCtrl
  import pscPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output ctrlStrobes_t     strobes
);
  logic syncMode;
  logic holdShared, holdSecond;
  logic pulseShared, pulseSecond;
  logic [MODE_BIT-SECOND_BIT-2:0] unusedResv;

  assign unusedResv = regWdata[MODE_BIT-1:SECOND_BIT+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncMode    <= 1'b0;
      holdShared  <= 1'b0;
      holdSecond  <= 1'b0;
      pulseShared <= 1'b0;
      pulseSecond <= 1'b0;
    end else begin
      pulseShared <= 1'b0;
      pulseSecond <= 1'b0;
      if (regWe) begin
        syncMode <= regWdata[MODE_BIT];
        if (regWdata[MODE_BIT]) begin
          holdShared <= regWdata[SHARED_BIT];
          holdSecond <= regWdata[SECOND_BIT];
        end else begin
          holdShared  <= 1'b0;
          holdSecond  <= 1'b0;
          pulseShared <= regWdata[SHARED_BIT];
          pulseSecond <= regWdata[SECOND_BIT];
        end
      end
    end
  end

  always_comb begin
    regRdata             = '0;
    regRdata[MODE_BIT]   = syncMode;
    regRdata[SECOND_BIT] = holdSecond;
    regRdata[SHARED_BIT] = holdShared;
  end

  assign strobes.rstShared = holdShared | pulseShared;
  assign strobes.rstSecond = holdSecond | pulseSecond;
endmodule

// File: rtl/pscPrescaler.sv
module pscPrescaler #(
  parameter int W     = 10,
  parameter int NTAPS = 5,
  parameter int TAP_SHIFT [NTAPS] = '{0, 3, 6, 8, 10}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  output logic [NTAPS-1:0] taps
);
  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN || restart) count <= '0;
    else                  count <= count + 1'b1;
  end

  for (genvar i = 0; i < NTAPS; i++) begin : gTap
    localparam logic [W-1:0] MASK = W'((1 << TAP_SHIFT[i]) - 1);
    assign taps[i] = !restart && ((count & MASK) == '0);
  end
endmodule

// File: rtl/pscTapCounter.sv
module pscTapCounter #(
  parameter int NTAPS = 5,
  parameter int SEL_W = 3,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NTAPS-1:0] taps,
  input  logic [SEL_W-1:0] sel,
  input  logic             load,
  input  logic [CW-1:0]    loadValue,
  output logic [CW-1:0]    count
);
  logic tick;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NTAPS; i++) begin
      if (int'(sel) == i + 1) tick = taps[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     count <= '0;
    else if (load) count <= loadValue;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/pscDatapath.sv
module pscDatapath
  import pscPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [SEL_W-1:0]     selA,
  input  logic [SEL_W-1:0]     selB,
  input  logic                 loadA,
  input  logic [CNT_W-1:0]     loadAValue,
  input  logic                 loadB,
  input  logic [CNT_W-1:0]     loadBValue,
  output logic [SHARED_NT-1:0] sharedTaps,
  output logic [SECOND_NT-1:0] secondTaps,
  output logic [CNT_W-1:0]     countA,
  output logic [CNT_W-1:0]     countB
);
  pscPrescaler #(.W(PRESC_W), .NTAPS(SHARED_NT), .TAP_SHIFT(SHARED_SHIFTS)) uSharedPre (
    .clk(clk), .rstN(rstN), .restart(strobes.rstShared), .taps(sharedTaps));

  pscPrescaler #(.W(PRESC_W), .NTAPS(SECOND_NT), .TAP_SHIFT(SECOND_SHIFTS)) uSecondPre (
    .clk(clk), .rstN(rstN), .restart(strobes.rstSecond), .taps(secondTaps));

  pscTapCounter #(.NTAPS(SHARED_NT), .SEL_W(SEL_W), .CW(CNT_W)) uCountA (
    .clk(clk), .rstN(rstN), .taps(sharedTaps), .sel(selA),
    .load(loadA), .loadValue(loadAValue), .count(countA));

  pscTapCounter #(.NTAPS(SECOND_NT), .SEL_W(SEL_W), .CW(CNT_W)) uCountB (
    .clk(clk), .rstN(rstN), .taps(secondTaps), .sel(selB),
    .load(loadB), .loadValue(loadBValue), .count(countB));
endmodule

// File: rtl/prescalerSyncTop.sv
module prescalerSyncTop
  import pscPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  output logic [SHARED_NT-1:0] sharedTaps,
  output logic [SECOND_NT-1:0] secondTaps,
  input  logic [SEL_W-1:0]     selA,
  input  logic [SEL_W-1:0]     selB,
  input  logic                 loadA,
  input  logic [CNT_W-1:0]     loadAValue,
  input  logic                 loadB,
  input  logic [CNT_W-1:0]     loadBValue,
  output logic [CNT_W-1:0]     countA,
  output logic [CNT_W-1:0]     countB
);
  ctrlStrobes_t strobes;

  pscCtrl uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .strobes(strobes));

  pscDatapath uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .selA(selA), .selB(selB), .loadA(loadA), .loadAValue(loadAValue),
    .loadB(loadB), .loadBValue(loadBValue),
    .sharedTaps(sharedTaps), .secondTaps(secondTaps),
    .countA(countA), .countB(countB));
endmodule

// File: rtl/pscChecker.sv
module pscChecker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdata,
  input logic       wrData0,
  input logic [4:0] sharedTaps,
  input logic [6:0] secondTaps,
  input logic [2:0] selA,
  input logic       loadA,
  input logic       loadB,
  input logic [7:0] countA,
  input logic [7:0] countB
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[6:2] == 5'b0);

  p_selfclear_r3: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[7] |-> regRdata[1:0] == 2'b00);

  p_shared_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[0] |-> sharedTaps == 5'b0);

  p_second_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[1] |-> secondTaps == 7'b0);

  p_freeze_a_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[0] && !loadA) |=> $stable(countA));

  p_freeze_b_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[1] && !loadB) |=> $stable(countB));

  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(regRdata[7]) && $past(regRdata[0]) && !$past(wrData0)) |-> sharedTaps == 5'h1F);

  p_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (selA == 3'd0 && !loadA) |=> $stable(countA));
endmodule

bind prescalerSyncTop pscChecker chk (
  .clk(clk), .rstN(rstN), .regRdata(regRdata), .wrData0(regWdata[0]),
  .sharedTaps(sharedTaps), .secondTaps(secondTaps), .selA(selA),
  .loadA(loadA), .loadB(loadB), .countA(countA), .countB(countB));

// File: tb/prescalerSyncTop_test.sv
`timescale 1ns/1ps
module prescalerSyncTop_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [4:0] sharedTaps;
  logic [6:0] secondTaps;
  logic [2:0] selA = 3'd0, selB = 3'd0;
  logic loadA = 1'b0, loadB = 1'b0;
  logic [7:0] loadAValue = 8'h00, loadBValue = 8'h00;
  logic [7:0] countA, countB;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";

  // behavioural reference state
  int mMode = 0, mHoldS = 0, mHoldB = 0, mPulS = 0, mPulB = 0;
  int mPreS = 0, mPreB = 0, mCntA = 0, mCntB = 0;
  int divS [5] = '{1, 8, 64, 256, 1024};
  int divB [7] = '{1, 8, 32, 64, 128, 256, 1024};

  prescalerSyncTop uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .sharedTaps(sharedTaps), .secondTaps(secondTaps), .selA(selA), .selB(selB),
    .loadA(loadA), .loadAValue(loadAValue), .loadB(loadB), .loadBValue(loadBValue),
    .countA(countA), .countB(countB));

  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int expShared();
    int v = 0;
    for (int i = 0; i < 5; i++)
      if (!(mHoldS || mPulS) && (mPreS % divS[i]) == 0) v |= (1 << i);
    return v;
  endfunction

  function automatic int expSecond();
    int v = 0;
    for (int i = 0; i < 7; i++)
      if (!(mHoldB || mPulB) && (mPreB % divB[i]) == 0) v |= (1 << i);
    return v;
  endfunction

  task automatic compareAll();
    check(tag, "regRdata", int'(regRdata), (mMode << 7) | (mHoldB << 1) | mHoldS);
    check(tag, "sharedTaps", int'(sharedTaps), expShared());
    check(tag, "secondTaps", int'(secondTaps), expSecond());
    check(tag, "countA", int'(countA), mCntA);
    check(tag, "countB", int'(countB), mCntB);
  endtask

  // inputs are already set (at a falling edge); advance model and design one clock
  task automatic step();
    int sT = expShared();
    int bT = expSecond();
    int nA = mCntA, nB = mCntB;
    int tickA = (selA >= 1 && selA <= 5) ? ((sT >> (selA - 1)) & 1) : 0;
    int tickB = (selB >= 1 && selB <= 7) ? ((bT >> (selB - 1)) & 1) : 0;
    if (loadA) nA = loadAValue; else if (tickA != 0) nA = (mCntA + 1) % 256;
    if (loadB) nB = loadBValue; else if (tickB != 0) nB = (mCntB + 1) % 256;
    mPreS = (mHoldS || mPulS) ? 0 : (mPreS + 1) % 1024;
    mPreB = (mHoldB || mPulB) ? 0 : (mPreB + 1) % 1024;
    mCntA = nA; mCntB = nB;
    mPulS = 0; mPulB = 0;
    if (regWe) begin
      mMode = regWdata[7];
      if (regWdata[7]) begin
        mHoldS = regWdata[0]; mHoldB = regWdata[1];
      end else begin
        mHoldS = 0; mHoldB = 0; mPulS = regWdata[0]; mPulB = regWdata[1];
      end
    end
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic writeReg(input logic [7:0] v);
    regWe = 1'b1; regWdata = v;
    step();
    regWe = 1'b0; regWdata = 8'h00;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tag = "R1";
    compareAll();
    check("R1", "reset register", int'(regRdata), 0);

    // free run, R8 R9 R10
    tag = "R10"; selA = 3'd1; selB = 3'd2; run(40);
    tag = "R2";
    writeReg(8'h7C); run(2);
    check("R2", "reserved bits ignored", int'(regRdata), 0);

    tag = "R3"; selA = 3'd2; run(13);
    writeReg(8'h01);
    check("R3", "shared taps silent during restart", int'(sharedTaps), 0);
    run(3);
    check("R3", "bit0 self-cleared", int'(regRdata[0]), 0);

    tag = "R4"; selB = 3'd1; run(5);
    writeReg(8'h02);
    check("R4", "second taps silent during restart", int'(secondTaps), 0);
    run(3);
    check("R4", "bit1 self-cleared", int'(regRdata[1]), 0);

    // hold both, load equal values, release together
    tag = "R5"; run(7);
    writeReg(8'h80);
    writeReg(8'h83);
    check("R5", "holds retained", int'(regRdata), 8'h83);
    run(20);
    check("R5", "shared taps silent while held", int'(sharedTaps), 0);
    tag = "R11";
    loadA = 1'b1; loadB = 1'b1; loadAValue = 8'h40; loadBValue = 8'h40;
    step();
    loadA = 1'b0; loadB = 1'b0;
    check("R11", "countA loaded", int'(countA), 8'h40);
    selA = 3'd2; selB = 3'd2; run(5);
    check("R5", "countA frozen", int'(countA), 8'h40);
    tag = "R6";
    writeReg(8'h00);
    check("R6", "all shared taps on release", int'(sharedTaps), 5'h1F);
    check("R6", "all second taps on release", int'(secondTaps), 7'h7F);
    check("R6", "register cleared", int'(regRdata), 0);
    tag = "R11"; run(100);
    check("R11", "lockstep", int'(countA), int'(countB));

    tag = "R7";
    writeReg(8'h81);
    check("R7", "combined write keeps bit0", int'(regRdata), 8'h81);
    run(10);
    writeReg(8'h00);

    // select sweep, R10
    tag = "R10";
    for (int s = 0; s < 8; s++) begin
      selA = 3'(s); selB = 3'(7 - s);
      run(300);
    end
    selA = 3'd0; run(4);
    check("R10", "select 0 holds count", int'(countA), mCntA);

    // long run covering the divide-by-1024 taps, R8 R9
    tag = "R8"; selA = 3'd5; selB = 3'd7; run(2100);
    tag = "R9"; selA = 3'd3; selB = 3'd3; run(2100);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule